// File: doc/BRIEF.md
# Data-Processing ALU With Condition Flags

This block is the combinational result-and-flags stage of a 32-bit integer datapath. It takes a first operand and an already shifted second operand, executes one of sixteen data-processing operations selected by a 4-bit opcode, and produces the result, a result-write enable and the next value of the four condition flags (negative, zero, carry, overflow). The barrel shifter sits in front of it. The shifter's carry-out arrives on its own pin, so logical operations can hand it on to the carry flag.

Three control bits shape how the flags behave. The first asks for flags to be set. The second says the destination is the program counter. The third says the current processor mode owns a saved status word. When a flag-setting operation targets the program counter in such a mode, the block computes no flags and instead raises a request for the surrounding core to copy the saved status back into the live status word. Compare-type operations always update flags and never write a result.

Top module: `alu_dp_core`

## Requirements
- R1: The opcode selects the operation. Logical operations give: 0000 a AND b, 0001 a XOR b, 1000 (test) a AND b, 1001 (test-equal) a XOR b, 1100 a OR b, 1101 b, 1110 a AND NOT b, 1111 NOT b. Arithmetic operations give: 0010 a-b, 0011 b-a, 0100 a+b, 0101 a+b+C, 0110 a-b-(1-C), 0111 b-a-(1-C), 1010 (compare) a-b, 1011 (compare-negative) a+b. The flag vector is {N,Z,C,V} on bits 3 down to 0.
- R2: For 0100, 0101 and 1011, when flags update, C is the unsigned carry out of bit 31 and V is signed overflow of the addition.
- R3: For 0010, 0011 and 1010, when flags update, C is 1 exactly when the subtraction does not borrow, and V is signed overflow of the subtraction.
- R4: 0101, 0110 and 0111 use the incoming C flag as carry-in, so the subtracting forms take away one more when C is 0.
- R5: For logical operations, when flags update, N is result bit 31, Z is 1 for a zero result, C is the shifter carry and V keeps its incoming value.
- R6: Opcodes 1000 to 1011 never assert the write enable and always update flags, whatever the set-flags bit is. All other opcodes assert the write enable.
- R7: With the set-flags bit at 0, the non-compare operations pass the incoming flags through unchanged.
- R8: When flags would update, the destination is the program counter and the mode has a saved status, the restore request is 1 and the outgoing flags equal the incoming flags. Otherwise the restore request is 0.
- R9: For 1101 and 1111 the first operand has no effect on the result or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 4 | Operation select (see R1) |
| set_flags | input | 1 | Update flags for non-compare operations |
| dst_is_pc | input | 1 | Destination register is the program counter |
| mode_has_saved | input | 1 | Current mode owns a saved status word |
| flags_in | input | 4 | Current {N,Z,C,V} |
| shift_carry | input | 1 | Carry-out from the shifter |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Shifter operand |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Result is to be written to the destination |
| flags_out | output | 4 | Next {N,Z,C,V} |
| restore_req | output | 1 | Request to restore the saved status word |

## Verification
The hardest case to reach is the restore request from a compare-type opcode. It needs the program-counter destination and the saved-status mode together while the set-flags bit is 0, because compares set flags implicitly. Other flag-setting paths mask it. The vector table drives this combination directly, with all four incoming flags at 1, so that held flags can be told apart from recomputed ones. It also pairs each carry-in operation with the incoming carry value that changes its result.

// File: rtl/alu_dp_pkg.sv
package alu_dp_pkg;

   typedef enum logic [3:0] {
      OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
      OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
      OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
      OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
   } alu_op_e;

   typedef enum logic [1:0] {
      CIN_ZERO = 2'd0,
      CIN_ONE  = 2'd1,
      CIN_FLAG = 2'd2
   } cin_sel_e;

   typedef enum logic [2:0] {
      LG_AND  = 3'd0,
      LG_XOR  = 3'd1,
      LG_OR   = 3'd2,
      LG_PASS = 3'd3,
      LG_ANDN = 3'd4,
      LG_NOT  = 3'd5
   } logic_sel_e;

   typedef struct packed {
      logic       is_arith;
      logic       is_cmp;
      logic       swap;
      logic       inv_y;
      cin_sel_e   cin_sel;
      logic_sel_e lsel;
   } alu_ctrl_t;

   localparam int FLG_N = 3;
   localparam int FLG_Z = 2;
   localparam int FLG_C = 1;
   localparam int FLG_V = 0;

endpackage

// File: rtl/alu_dp_decode.sv
module alu_dp_decode
   import alu_dp_pkg::*;
(
   input  logic [3:0] opcode,
   output alu_ctrl_t  ctrl
);

   always_comb begin
      ctrl          = '0;
      ctrl.cin_sel  = CIN_ZERO;
      ctrl.lsel     = LG_AND;
      ctrl.is_cmp   = (opcode[3:2] == 2'b10);
      unique case (alu_op_e'(opcode))
         OP_SUB, OP_CMP: begin
            ctrl.is_arith = 1'b1;
            ctrl.inv_y    = 1'b1;
            ctrl.cin_sel  = CIN_ONE;
         end
         OP_RSB: begin
            ctrl.is_arith = 1'b1;
            ctrl.swap     = 1'b1;
            ctrl.inv_y    = 1'b1;
            ctrl.cin_sel  = CIN_ONE;
         end
         OP_ADD, OP_CMN: begin
            ctrl.is_arith = 1'b1;
         end
         OP_ADC: begin
            ctrl.is_arith = 1'b1;
            ctrl.cin_sel  = CIN_FLAG;
         end
         OP_SBC: begin
            ctrl.is_arith = 1'b1;
            ctrl.inv_y    = 1'b1;
            ctrl.cin_sel  = CIN_FLAG;
         end
         OP_RSC: begin
            ctrl.is_arith = 1'b1;
            ctrl.swap     = 1'b1;
            ctrl.inv_y    = 1'b1;
            ctrl.cin_sel  = CIN_FLAG;
         end
         OP_AND, OP_TST: ctrl.lsel = LG_AND;
         OP_EOR, OP_TEQ: ctrl.lsel = LG_XOR;
         OP_ORR:         ctrl.lsel = LG_OR;
         OP_MOV:         ctrl.lsel = LG_PASS;
         OP_BIC:         ctrl.lsel = LG_ANDN;
         OP_MVN:         ctrl.lsel = LG_NOT;
         default:        ctrl.lsel = LG_AND;
      endcase
   end

endmodule

// File: rtl/alu_dp_adder.sv
module alu_dp_adder #(
   parameter int DATA_W    = 32,
   parameter bit SPLIT_ADD = 1'b0
) (
   input  logic [DATA_W-1:0] x,
   input  logic [DATA_W-1:0] y,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic              cout
);

   localparam int LO_W = DATA_W / 2;
   localparam int HI_W = DATA_W - LO_W;

   generate
      if (SPLIT_ADD) begin : g_csel
         logic [LO_W:0] lo;
         logic [HI_W:0] hi0;
         logic [HI_W:0] hi1;
         always_comb begin
            lo  = {1'b0, x[LO_W-1:0]} + {1'b0, y[LO_W-1:0]} + {{LO_W{1'b0}}, cin};
            hi0 = {1'b0, x[DATA_W-1:LO_W]} + {1'b0, y[DATA_W-1:LO_W]};
            hi1 = {1'b0, x[DATA_W-1:LO_W]} + {1'b0, y[DATA_W-1:LO_W]}
                  + {{HI_W{1'b0}}, 1'b1};
            if (lo[LO_W]) begin
               sum  = {hi1[HI_W-1:0], lo[LO_W-1:0]};
               cout = hi1[HI_W];
            end else begin
               sum  = {hi0[HI_W-1:0], lo[LO_W-1:0]};
               cout = hi0[HI_W];
            end
         end
      end else begin : g_flat
         logic [DATA_W:0] full;
         always_comb begin
            full = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
            sum  = full[DATA_W-1:0];
            cout = full[DATA_W];
         end
      end
   endgenerate

endmodule

// File: rtl/alu_dp_logic.sv
module alu_dp_logic
   import alu_dp_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic_sel_e        lsel,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);

   always_comb begin
      unique case (lsel)
         LG_AND:  y = a & b;
         LG_XOR:  y = a ^ b;
         LG_OR:   y = a | b;
         LG_PASS: y = b;
         LG_ANDN: y = a & ~b;
         LG_NOT:  y = ~b;
         default: y = a & b;
      endcase
   end

endmodule

// File: rtl/alu_dp_flags.sv
module alu_dp_flags
   import alu_dp_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              is_arith,
   input  logic              is_cmp,
   input  logic              set_flags,
   input  logic              dst_is_pc,
   input  logic              mode_has_saved,
   input  logic [3:0]        flags_in,
   input  logic              shift_carry,
   input  logic [DATA_W-1:0] res,
   input  logic              x_msb,
   input  logic              y_msb,
   input  logic              add_cout,
   output logic [3:0]        flags_out,
   output logic              restore_req
);

   localparam int MSB = DATA_W - 1;

   logic want_flags;
   logic update;
   logic n_new, z_new, c_new, v_new;

   always_comb begin
      want_flags  = set_flags | is_cmp;
      restore_req = want_flags & dst_is_pc & mode_has_saved;
      update      = want_flags & ~restore_req;
      n_new       = res[MSB];
      z_new       = (res == '0);
      c_new       = is_arith ? add_cout : shift_carry;
      v_new       = is_arith ? ((x_msb == y_msb) && (res[MSB] != x_msb))
                             : flags_in[FLG_V];
      flags_out   = update ? {n_new, z_new, c_new, v_new} : flags_in;
   end

endmodule

// File: rtl/alu_dp_core.sv
module alu_dp_core
   import alu_dp_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit SPLIT_ADD = 1'b0
) (
   input  logic [3:0]        opcode,
   input  logic              set_flags,
   input  logic              dst_is_pc,
   input  logic              mode_has_saved,
   input  logic [3:0]        flags_in,
   input  logic              shift_carry,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   output logic [DATA_W-1:0] result,
   output logic              wr_en,
   output logic [3:0]        flags_out,
   output logic              restore_req
);

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("alu_dp_core: DATA_W must be at least 4");
      end
   endgenerate

   alu_ctrl_t         ctrl;
   logic [DATA_W-1:0] add_x, add_y, add_sum, lg_res;
   logic              add_cin, add_cout;

   alu_dp_decode u_dec (
      .opcode (opcode),
      .ctrl   (ctrl)
   );

   always_comb begin
      add_x = ctrl.swap ? op_b : op_a;
      add_y = ctrl.swap ? op_a : op_b;
      if (ctrl.inv_y) add_y = ~add_y;
      unique case (ctrl.cin_sel)
         CIN_ONE:  add_cin = 1'b1;
         CIN_FLAG: add_cin = flags_in[FLG_C];
         default:  add_cin = 1'b0;
      endcase
   end

   alu_dp_adder #(.DATA_W(DATA_W), .SPLIT_ADD(SPLIT_ADD)) u_add (
      .x    (add_x),
      .y    (add_y),
      .cin  (add_cin),
      .sum  (add_sum),
      .cout (add_cout)
   );

   alu_dp_logic #(.DATA_W(DATA_W)) u_lg (
      .lsel (ctrl.lsel),
      .a    (op_a),
      .b    (op_b),
      .y    (lg_res)
   );

   assign result = ctrl.is_arith ? add_sum : lg_res;
   assign wr_en  = ~ctrl.is_cmp;

   alu_dp_flags #(.DATA_W(DATA_W)) u_flg (
      .is_arith       (ctrl.is_arith),
      .is_cmp         (ctrl.is_cmp),
      .set_flags      (set_flags),
      .dst_is_pc      (dst_is_pc),
      .mode_has_saved (mode_has_saved),
      .flags_in       (flags_in),
      .shift_carry    (shift_carry),
      .res            (result),
      .x_msb          (add_x[DATA_W-1]),
      .y_msb          (add_y[DATA_W-1]),
      .add_cout       (add_cout),
      .flags_out      (flags_out),
      .restore_req    (restore_req)
   );

endmodule

// File: rtl/alu_dp_core_chk.sv
module alu_dp_core_chk #(
   parameter int DATA_W = 32
) (
   input logic [3:0]        opcode,
   input logic              set_flags,
   input logic              dst_is_pc,
   input logic              mode_has_saved,
   input logic [3:0]        flags_in,
   input logic              shift_carry,
   input logic [DATA_W-1:0] op_a,
   input logic [DATA_W-1:0] op_b,
   input logic [DATA_W-1:0] result,
   input logic              wr_en,
   input logic [3:0]        flags_out,
   input logic              restore_req
);

   logic cmp_op, logic_op, flag_req;

   always_comb begin
      cmp_op   = (opcode[3:2] == 2'b10);
      logic_op = (opcode[3:2] == 2'b11) || (opcode[3:1] == 3'b000)
                 || (opcode[3:1] == 3'b100);
      flag_req = set_flags | cmp_op;

      p_cmp_no_write_r6: assert (!(cmp_op && wr_en))
         else $error("compare opcode wrote a result");
      p_other_write_r6: assert (cmp_op || wr_en)
         else $error("non-compare opcode did not write");
      p_flags_hold_r7: assert (flag_req || flags_out == flags_in)
         else $error("flags moved without set-flags");
      p_restore_cond_r8: assert (restore_req == (flag_req && dst_is_pc && mode_has_saved))
         else $error("restore request mismatch");
      p_restore_hold_r8: assert (!restore_req || flags_out == flags_in)
         else $error("flags changed during restore");
      p_logic_v_r5: assert (!logic_op || flags_out[0] == flags_in[0])
         else $error("logical op altered V");
      p_logic_c_r5: assert (!(logic_op && flag_req && !restore_req)
                            || flags_out[1] == shift_carry)
         else $error("logical op C not from shifter");
      p_zero_flag_r5: assert (!(flag_req && !restore_req)
                              || flags_out[2] == (result == '0))
         else $error("Z does not match result");
      p_neg_flag_r5: assert (!(flag_req && !restore_req)
                             || flags_out[3] == result[DATA_W-1])
         else $error("N does not match result");
   end

endmodule

bind alu_dp_core alu_dp_core_chk #(.DATA_W(DATA_W)) u_chk (
   .opcode         (opcode),
   .set_flags      (set_flags),
   .dst_is_pc      (dst_is_pc),
   .mode_has_saved (mode_has_saved),
   .flags_in       (flags_in),
   .shift_carry    (shift_carry),
   .op_a           (op_a),
   .op_b           (op_b),
   .result         (result),
   .wr_en          (wr_en),
   .flags_out      (flags_out),
   .restore_req    (restore_req)
);

// File: tb/alu_dp_core_tb.sv
module alu_dp_core_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  opcode = 4'h0;
   logic        set_flags = 1'b0, dst_is_pc = 1'b0, mode_has_saved = 1'b0;
   logic [3:0]  flags_in = 4'h0;
   logic        shift_carry = 1'b0;
   logic [31:0] op_a = '0, op_b = '0;
   logic [31:0] result;
   logic        wr_en, restore_req;
   logic [3:0]  flags_out;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   always #4 clk = ~clk;

   alu_dp_core dut_i (
      .opcode (opcode), .set_flags (set_flags), .dst_is_pc (dst_is_pc),
      .mode_has_saved (mode_has_saved), .flags_in (flags_in),
      .shift_carry (shift_carry), .op_a (op_a), .op_b (op_b),
      .result (result), .wr_en (wr_en), .flags_out (flags_out),
      .restore_req (restore_req)
   );

   typedef struct packed {
      logic [3:0]  req;
      logic [3:0]  op;
      logic        s;
      logic        pc;
      logic        sv;
      logic [3:0]  fl;
      logic        sc;
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] res;
      logic        we;
      logic [3:0]  flo;
      logic        rst;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t TBL [NV] = '{
      // R2 add wrap to zero, carry out
      '{4'd2, 4'h4, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 32'hFFFFFFFF, 32'h1, 32'h0, 1'b1, 4'h6, 1'b0},
      // R2 add signed overflow
      '{4'd2, 4'h4, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 32'h7FFFFFFF, 32'h1, 32'h80000000, 1'b1, 4'h9, 1'b0},
      // R3 subtract with borrow
      '{4'd3, 4'h2, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 32'h5, 32'h7, 32'hFFFFFFFE, 1'b1, 4'h8, 1'b0},
      // R3 subtract without borrow
      '{4'd3, 4'h2, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 32'h7, 32'h5, 32'h2, 1'b1, 4'h2, 1'b0},
      // R3 reverse subtract
      '{4'd3, 4'h3, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 32'h5, 32'h7, 32'h2, 1'b1, 4'h2, 1'b0},
      // R4 add with carry in
      '{4'd4, 4'h5, 1'b1, 1'b0, 1'b0, 4'h2, 1'b0, 32'h1, 32'h2, 32'h4, 1'b1, 4'h0, 1'b0},
      // R4 subtract with C clear takes one more
      '{4'd4, 4'h6, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 32'hA, 32'h3, 32'h6, 1'b1, 4'h2, 1'b0},
      // R4 reverse subtract with C set
      '{4'd4, 4'h7, 1'b1, 1'b0, 1'b0, 4'h2, 1'b0, 32'h3, 32'hA, 32'h7, 1'b1, 4'h2, 1'b0},
      // R6 compare equal, set-flags off
      '{4'd6, 4'hA, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 32'h3, 32'h3, 32'h0, 1'b0, 4'h6, 1'b0},
      // R6 compare-negative overflow
      '{4'd6, 4'hB, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 32'h80000000, 32'h80000000, 32'h0, 1'b0, 4'h7, 1'b0},
      // R5 test: C from shifter, V held
      '{4'd5, 4'h8, 1'b0, 1'b0, 1'b0, 4'h1, 1'b1, 32'hF0, 32'h0F, 32'h0, 1'b0, 4'h7, 1'b0},
      // R5 test-equal negative
      '{4'd5, 4'h9, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 32'h80000000, 32'h0, 32'h80000000, 1'b0, 4'h8, 1'b0},
      // R7 or without set-flags
      '{4'd7, 4'hC, 1'b0, 1'b0, 1'b0, 4'hA, 1'b0, 32'h1, 32'h2, 32'h3, 1'b1, 4'hA, 1'b0},
      // R5 move zero, V kept
      '{4'd5, 4'hD, 1'b1, 1'b0, 1'b0, 4'h1, 1'b0, 32'hDEADBEEF, 32'h0, 32'h0, 1'b1, 4'h5, 1'b0},
      // R5 move-not
      '{4'd5, 4'hF, 1'b1, 1'b0, 1'b0, 4'h0, 1'b1, 32'h123, 32'h0, 32'hFFFFFFFF, 1'b1, 4'hA, 1'b0},
      // R1 bit clear
      '{4'd1, 4'hE, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 32'hFF, 32'h0F, 32'hF0, 1'b1, 4'h0, 1'b0},
      // R7 xor without set-flags
      '{4'd7, 4'h1, 1'b0, 1'b0, 1'b0, 4'h6, 1'b0, 32'hFF, 32'hF0, 32'h0F, 1'b1, 4'h6, 1'b0},
      // R1 and
      '{4'd1, 4'h0, 1'b1, 1'b0, 1'b0, 4'h0, 1'b1, 32'hFF, 32'hF0, 32'hF0, 1'b1, 4'h2, 1'b0},
      // R8 flag-setting subtract to PC in saved mode
      '{4'd8, 4'h2, 1'b1, 1'b1, 1'b1, 4'h0, 1'b0, 32'h5, 32'h7, 32'hFFFFFFFE, 1'b1, 4'h0, 1'b1},
      // R8 PC destination, no saved status: normal flags
      '{4'd8, 4'h2, 1'b1, 1'b1, 1'b0, 4'h0, 1'b0, 32'h7, 32'h5, 32'h2, 1'b1, 4'h2, 1'b0},
      // R8 compare restores even with set-flags off
      '{4'd8, 4'hA, 1'b0, 1'b1, 1'b1, 4'hF, 1'b0, 32'h1, 32'h1, 32'h0, 1'b0, 4'hF, 1'b1},
      // R8 saved mode but not PC destination
      '{4'd8, 4'h4, 1'b1, 1'b0, 1'b1, 4'h0, 1'b0, 32'h1, 32'h1, 32'h2, 1'b1, 4'h0, 1'b0}
   };

   task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [3:0] op, input logic s, input logic pc,
                        input logic sv, input logic [3:0] fl, input logic sc,
                        input logic [31:0] a, input logic [31:0] b);
      @(posedge clk);
      #2;
      opcode = op; set_flags = s; dst_is_pc = pc; mode_has_saved = sv;
      flags_in = fl; shift_carry = sc; op_a = a; op_b = b;
      #2;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   logic [31:0] r_ref;
   logic [3:0]  f_ref;

   initial begin
      // R1 idle state during reset: opcode 0000 with zero operands
      repeat (3) @(posedge clk);
      #2;
      chk32("R1 reset result", result, 32'h0);
      chk32("R6 reset wr_en", {31'b0, wr_en}, 32'h1);
      chk32("R7 reset flags", {28'b0, flags_out}, 32'h0);
      chk32("R8 reset restore", {31'b0, restore_req}, 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         drive(TBL[i].op, TBL[i].s, TBL[i].pc, TBL[i].sv, TBL[i].fl,
               TBL[i].sc, TBL[i].a, TBL[i].b);
         if (TBL[i].we)
            chk32($sformatf("R%0d vec %0d result", TBL[i].req, i), result, TBL[i].res);
         chk32($sformatf("R6 vec %0d wr_en", i), {31'b0, wr_en}, {31'b0, TBL[i].we});
         chk32($sformatf("R%0d vec %0d flags", TBL[i].req, i),
               {28'b0, flags_out}, {28'b0, TBL[i].flo});
         chk32($sformatf("R8 vec %0d restore", i),
               {31'b0, restore_req}, {31'b0, TBL[i].rst});
      end

      // R9: first operand ignored by move and move-not
      for (int k = 0; k < 4; k++) begin
         logic [31:0] av;
         av = (k == 0) ? 32'h0 : (k == 1) ? 32'hFFFFFFFF : (k == 2) ? 32'h80000001 : 32'h5A5A5A5A;
         drive(4'hD, 1'b1, 1'b0, 1'b0, 4'h0, 1'b1, av, 32'h00001234);
         chk32("R9 move result", result, 32'h00001234);
         chk32("R9 move flags", {28'b0, flags_out}, 32'h2);
         drive(4'hF, 1'b1, 1'b0, 1'b0, 4'h1, 1'b0, av, 32'hFFFFFFFF);
         chk32("R9 move-not result", result, 32'h0);
         chk32("R9 move-not flags", {28'b0, flags_out}, 32'h5);
      end

      // R4: same operands, carry flag toggled, result differs by one
      drive(4'h5, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 32'hFFFFFFFE, 32'h1);
      r_ref = 32'hFFFFFFFF;
      chk32("R4 adc C=0", result, r_ref);
      drive(4'h5, 1'b1, 1'b0, 1'b0, 4'h2, 1'b0, 32'hFFFFFFFE, 32'h1);
      f_ref = 4'h6;
      chk32("R4 adc C=1 result", result, 32'h0);
      chk32("R4 adc C=1 flags", {28'b0, flags_out}, {28'b0, f_ref});

      // R3: subtract-type overflow, 0x80000000 - 1
      drive(4'h2, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 32'h80000000, 32'h1);
      chk32("R3 sub overflow result", result, 32'h7FFFFFFF);
      chk32("R3 sub overflow flags", {28'b0, flags_out}, 32'h3);

      // R7: set-flags off with PC destination in saved mode, non-compare
      drive(4'h4, 1'b0, 1'b1, 1'b1, 4'h9, 1'b1, 32'h1, 32'h1);
      chk32("R7 add no-s flags", {28'b0, flags_out}, 32'h9);
      chk32("R8 add no-s restore", {31'b0, restore_req}, 32'h0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule